// File: doc/BRIEF.md
# FPGA Configuration Supervisor

This block runs on the host side of a board and supervises how a target FPGA loads its configuration. It drives the target's active-low configuration request line and watches three lines coming back from the target: the active-low status line, the load-complete line and the initialization-complete line. On a request it pulses the configuration line low for a fixed minimum time. It then waits for the target to release status, waits for the load to complete, and waits for the rising edge of initialization-complete. At that rising edge it reports that the target is in user mode.

A load error shows as status dropping while load-complete is still low. The `auto_restart_i` input selects how the block recovers. With the input low, the block drives a new configuration pulse itself. With the input high, the target restarts on its own after a short internal timeout, so the block only waits for status to come back, and a watchdog catches a target that never releases it. A retry counter caps the number of recoveries. When the cap is exceeded, the block sets a sticky error flag and returns to idle.

Top module: `cfg_supervisor`

## Requirements
- R1: After reset, config_n_o is 1 and user_mode_o, error_o and busy_o are 0.
- R2: A request accepted in idle drives config_n_o low for exactly PULSE_CYCLES clock cycles. busy_o is 1 whenever config_n_o is 0.
- R3: After the pulse, the block waits for status_n_i=1 and then for conf_done_i=1. user_mode_o stays 0 until init_done_i rises, then becomes 1 and busy_o becomes 0.
- R4: user_mode_o is set only by a 0-to-1 transition of init_done_i after conf_done_i=1. If init_done_i is already high at that point, it does not count.
- R5: With auto_restart_i=0, a fault (status_n_i=0 while conf_done_i=0 during loading) causes a new config_n_o low pulse of PULSE_CYCLES cycles.
- R6: With auto_restart_i=1, a fault causes no config_n_o pulse. The block waits for status_n_i=1 and then resumes loading.
- R7: While waiting for status release, if status_n_i stays 0 for WDOG_CYCLES cycles, error_o is set and the block returns to idle (busy_o=0).
- R8: The first MAX_RETRIES faults of one configuration attempt are retried. The next fault sets error_o, with busy_o=0 and config_n_o=1. error_o stays set until the next accepted request clears it.
- R9: A request in user mode clears user_mode_o and drives config_n_o low on the first clock edge that samples it, for PULSE_CYCLES cycles.
- R10: Requests made while busy_o=1 have no effect: the pulse length does not change and no new pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_n_i | input | 1 | Target status, active low, asynchronous |
| conf_done_i | input | 1 | Target load complete, asynchronous |
| init_done_i | input | 1 | Target initialization complete, asynchronous |
| auto_restart_i | input | 1 | 1: target restarts itself after a fault; 0: block drives the restart pulse |
| reconfig_req_i | input | 1 | Configuration request, sampled each cycle |
| config_n_o | output | 1 | Configuration request to the target, active low |
| user_mode_o | output | 1 | Target is in user mode |
| error_o | output | 1 | Sticky failure flag |
| busy_o | output | 1 | A configuration attempt is in progress |

## Verification
A wrong state register shows at the ports within one clock. config_n_o, user_mode_o and busy_o are decoded directly from the state, so a stray state produces a pulse that is too short or too long, a missing pulse, or user mode reported while busy. A broken pulse or watchdog counter shows as a config_n_o low time that is not PULSE_CYCLES, or as error_o appearing too early or never. A broken retry count shows as error_o latching after the wrong number of injected faults. An edge detector that is wrong shows as user_mode_o rising while init_done_i is held steady high.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT_REL,
    ST_LOADING,
    ST_WAIT_INIT,
    ST_USER
  } cfg_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[0] <= RST_VAL;
        else         stg[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_retry.sv
module cfg_retry #(
  parameter int unsigned LIMIT = 3,
  parameter int unsigned W     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic exhausted_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + W'(1);

  assign exhausted_o = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/cfg_supervisor.sv
module cfg_supervisor
  import cfg_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 2000,  // >= 40 us at 50 MHz
  parameter int unsigned WDOG_CYCLES  = 5000,  // well beyond the ~30 us self-restart
  parameter int unsigned MAX_RETRIES  = 3,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic status_n_i,
  input  logic conf_done_i,
  input  logic init_done_i,
  input  logic auto_restart_i,
  input  logic reconfig_req_i,
  output logic config_n_o,
  output logic user_mode_o,
  output logic error_o,
  output logic busy_o
);
  localparam int unsigned CNT_MAX = (PULSE_CYCLES > WDOG_CYCLES) ? PULSE_CYCLES : WDOG_CYCLES;
  localparam int unsigned TW      = $clog2(CNT_MAX + 1);
  localparam int unsigned RW      = (MAX_RETRIES < 1) ? 1 : $clog2(MAX_RETRIES + 1);
  localparam logic [TW-1:0] PULSE_LD = TW'(PULSE_CYCLES - 1);
  localparam logic [TW-1:0] WDOG_LD  = TW'(WDOG_CYCLES - 1);

  cfg_state_e state_q, state_d;
  logic [2:0] sync_q;
  logic status_s, conf_s, init_s, init_prev_q, init_rise;
  logic tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic rty_clr, rty_inc, rty_exh;
  logic err_set, err_clr, err_q;

  cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({init_done_i, conf_done_i, status_n_i}),
    .q_o (sync_q)
  );
  assign status_s = sync_q[0];
  assign conf_s   = sync_q[1];
  assign init_s   = sync_q[2];

  cfg_timer #(.W(TW)) u_timer (
    .clk_i, .rst_ni,
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  cfg_retry #(.LIMIT(MAX_RETRIES), .W(RW)) u_retry (
    .clk_i, .rst_ni,
    .clr_i       (rty_clr),
    .inc_i       (rty_inc),
    .exhausted_o (rty_exh)
  );

  assign init_rise = init_s & ~init_prev_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = PULSE_LD;
    rty_clr  = 1'b0;
    rty_inc  = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (reconfig_req_i) begin
        state_d  = ST_PULSE;
        tmr_load = 1'b1;
        rty_clr  = 1'b1;
        err_clr  = 1'b1;
      end
      ST_PULSE: if (tmr_exp) begin
        state_d  = ST_WAIT_REL;
        tmr_load = 1'b1;
        tmr_val  = WDOG_LD;
      end
      ST_WAIT_REL: begin
        if (status_s) state_d = ST_LOADING;
        else if (tmr_exp) begin
          err_set = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_LOADING: begin
        if (conf_s) state_d = ST_WAIT_INIT;
        else if (!status_s) begin
          if (rty_exh) begin
            err_set = 1'b1;
            state_d = ST_IDLE;
          end else begin
            rty_inc  = 1'b1;
            tmr_load = 1'b1;
            if (auto_restart_i) begin
              state_d = ST_WAIT_REL;  // target restarts itself
              tmr_val = WDOG_LD;
            end else begin
              state_d = ST_PULSE;
            end
          end
        end
      end
      ST_WAIT_INIT: if (init_rise) state_d = ST_USER;
      ST_USER: if (reconfig_req_i) begin
        state_d  = ST_PULSE;
        tmr_load = 1'b1;
        rty_clr  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      init_prev_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      init_prev_q <= init_s;
      if (err_clr)      err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
    end

  assign config_n_o  = (state_q != ST_PULSE);
  assign user_mode_o = (state_q == ST_USER);
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_USER);
  assign error_o     = err_q;
endmodule

// File: rtl/cfg_supervisor_chk.sv
module cfg_supervisor_chk #(
  parameter int unsigned PULSE_CYCLES = 2000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic auto_restart_i,
  input logic config_n_o,
  input logic user_mode_o,
  input logic error_o,
  input logic busy_o
);
  logic [31:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          low_run_q <= '0;
    else if (!config_n_o) low_run_q <= low_run_q + 32'd1;
    else                  low_run_q <= '0;

  p_pulse_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (config_n_o && !$past(config_n_o)) |-> (low_run_q >= PULSE_CYCLES));

  p_busy_in_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !config_n_o |-> busy_o);

  p_user_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_mode_o |-> (!busy_o && config_n_o));

  p_auto_no_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(config_n_o) && auto_restart_i) |-> !$past(busy_o));

  p_error_parked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!busy_o && !user_mode_o));
endmodule

bind cfg_supervisor cfg_supervisor_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .auto_restart_i (auto_restart_i),
  .config_n_o     (config_n_o),
  .user_mode_o    (user_mode_o),
  .error_o        (error_o),
  .busy_o         (busy_o)
);

// File: tb/cfg_supervisor_bench.sv
module cfg_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P = 20;
  localparam int W = 40;
  localparam int R = 2;
  // row: [3]=auto_restart, [2:1]=faults injected, [0]=error expected
  localparam logic [3:0] ROW_TAB [6] = '{4'b0000, 4'b0010, 4'b1010, 4'b0111, 4'b1100, 4'b1111};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic status_n = 1'b1, conf_done = 1'b0, init_done = 1'b1, auto_rs = 1'b0, req = 1'b0;
  logic config_n, user_mode, error, busy;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_supervisor #(.PULSE_CYCLES(P), .WDOG_CYCLES(W), .MAX_RETRIES(R)) u_cfg_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .status_n_i(status_n), .conf_done_i(conf_done),
    .init_done_i(init_done), .auto_restart_i(auto_rs), .reconfig_req_i(req),
    .config_n_o(config_n), .user_mode_o(user_mode), .error_o(error), .busy_o(busy)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  // target model: holds status and done low while config_n is low
  task automatic wait_pulse(output int len);
    len = 0;
    for (int i = 0; i < 300 && config_n; i++) @(negedge clk);
    if (!config_n) begin
      status_n = 1'b0; conf_done = 1'b0;
      while (!config_n) begin len++; @(negedge clk); end
    end
  endtask

  task automatic release_to_loading();
    step(3); status_n = 1'b1; step(6);
  endtask

  task automatic finish_load(string tag);
    conf_done = 1'b1; init_done = 1'b0;
    step(6);
    check({tag, " user_mode during init"}, user_mode, 0);
    init_done = 1'b1;
    step(4);
    check({tag, " user_mode after init rise"}, user_mode, 1);
    check({tag, " busy in user mode"}, busy, 0);
  endtask

  task automatic run_row(logic ar, int nerr, logic exp_err);
    int len, low;
    auto_rs = ar; step(1);
    request();
    check("R8 error cleared by request", error, 0);
    check("R2 busy after request", busy, 1);
    wait_pulse(len);
    check("R2 pulse length", len, P);
    for (int e = 0; e < nerr; e++) begin
      release_to_loading();
      status_n = 1'b0;  // fault while conf_done low
      if (e == R) begin
        step(6);
        check("R8 error after retries", error, 1);
        check("R8 busy after retries", busy, 0);
        check("R8 config_n idle", config_n, 1);
        check("R8 expected error row", 1, int'(exp_err));
        return;
      end
      if (!ar) begin
        wait_pulse(len);
        check("R5 host restart pulse", len, P);
      end else begin
        low = 0;
        repeat (12) begin @(negedge clk); if (!config_n) low++; end
        check("R6 no pulse in auto mode", low, 0);
        check("R6 busy while waiting", busy, 1);
      end
    end
    check("R8 no error expected", int'(exp_err), 0);
    release_to_loading();
    finish_load("R3");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int len;
    step(3);
    check("R1 config_n reset", config_n, 1);
    check("R1 user_mode reset", user_mode, 0);
    check("R1 error reset", error, 0);
    check("R1 busy reset", busy, 0);
    rst_ni = 1'b1;
    step(2);

    foreach (ROW_TAB[i])
      run_row(ROW_TAB[i][3], int'(ROW_TAB[i][2:1]), ROW_TAB[i][0]);

    // R9: reconfigure from user mode
    run_row(1'b0, 0, 1'b0);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    check("R9 user_mode cleared", user_mode, 0);
    check("R9 config_n low", config_n, 0);
    wait_pulse(len);
    check("R9 pulse length", len, P);
    release_to_loading();
    finish_load("R9");

    // R10: requests while busy are ignored
    request();
    len = 0; status_n = 1'b0; conf_done = 1'b0;
    while (!config_n && len < 300) begin
      len++;
      req = (len == 5);
      @(negedge clk);
    end
    req = 1'b0;
    check("R10 pulse length with request", len, P);
    req = 1'b1; step(1); req = 1'b0;
    len = 0;
    repeat (4) begin @(negedge clk); if (!config_n) len++; end
    check("R10 no pulse from request in wait", len, 0);
    check("R10 still busy", busy, 1);
    release_to_loading();
    finish_load("R10");

    // R4: init_done already high does not count
    request(); wait_pulse(len); release_to_loading();
    init_done = 1'b1; conf_done = 1'b1;
    step(10);
    check("R4 no user_mode on steady init", user_mode, 0);
    check("R4 busy while waiting init", busy, 1);
    init_done = 1'b0; step(4); init_done = 1'b1; step(4);
    check("R4 user_mode on init rise", user_mode, 1);

    // R7: auto-mode watchdog
    auto_rs = 1'b1; step(1);
    request(); wait_pulse(len); release_to_loading();
    status_n = 1'b0;
    len = 0;
    repeat (W + 10) begin @(negedge clk); if (!config_n) len++; end
    check("R7 watchdog error", error, 1);
    check("R7 busy after watchdog", busy, 0);
    check("R7 no pulse during wait", len, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule